// File: doc/BRIEF.md
# Port Edge Event Capture

This block watches a parallel input port and asks a message controller to send the port state whenever an armed edge appears on any pin. Each pin carries two arm bits, one for low-to-high and one for high-to-low transitions, held in two mask registers that a local write port loads. A pin with neither bit set can still be read through a poll, but it never starts a transmission on its own. Besides edges, a poll request and a sign-on request also raise the same single pending-transmit flag. A sign-on request waits until the bit-time calibration reports done.

The port value is not frozen when the edge is seen. It is copied into the transmit data register only when the controller strobes that the frame header has gone out. This gives the inputs time to settle, and any change made after the edge is carried in the frame. A transmit-done pulse retires the request. Edges that arrive while a request is pending fold into it. A trigger that lands in the same cycle as transmit-done starts a fresh request. Pin inputs pass through a two-stage synchroniser before edge detection.

Top module: `port_event_capture`

## Requirements
- R1: After reset, tx_pend_o and tx_data_o are 0, and both arm masks are 0, so no pin transition raises tx_pend_o.
- R2: With bit n of the rise mask at 1, a 0-to-1 change on pins_i[n] made between clock edges raises tx_pend_o after the third rising clock edge that follows the change. A 1-to-0 change with only the rise bit set raises nothing.
- R3: With bit n of the fall mask at 1, a 1-to-0 change on pins_i[n] raises tx_pend_o with the same latency as R2. With both bits set, either direction triggers.
- R4: A pin with both mask bits at 0 never raises tx_pend_o, whatever it does.
- R5: At a clock edge where hdr_sent_i is 1 and tx_pend_o is 1, tx_data_o loads the synchronised port value. That value is the level pins_i held before the second-to-last clock edge.
- R6: Pin changes made after the triggering edge but before the header strobe appear in tx_data_o, including changes on pins that are not armed.
- R7: poll_req_i high at a clock edge makes tx_pend_o 1 after that edge, whatever the masks hold.
- R8: A signon_req_i pulse arms one sign-on request. tx_pend_o rises after the first later clock edge at which calib_done_i is 1, and only once per pulse.
- R9: tx_done_i high at an edge while no trigger is present clears tx_pend_o. Without tx_done_i, tx_pend_o stays 1.
- R10: Triggers that arrive while tx_pend_o is 1 merge into it, so one tx_done_i pulse leaves the flag at 0.
- R11: A trigger present at the same edge as tx_done_i leaves tx_pend_o at 1.
- R12: tx_data_o keeps its value at every edge where hdr_sent_i and tx_pend_o are not both 1.
- R13: cfg_wr_i at a clock edge writes cfg_data_i to the rise mask when cfg_sel_i is 0, or to the fall mask when it is 1. The new mask governs edges from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | WIDTH | Asynchronous port inputs |
| cfg_wr_i | input | 1 | Mask write strobe |
| cfg_sel_i | input | 1 | Mask select: 0 rise, 1 fall |
| cfg_data_i | input | WIDTH | Mask write data |
| poll_req_i | input | 1 | Remote poll request pulse |
| signon_req_i | input | 1 | Wake-up or bus-mode-change pulse |
| calib_done_i | input | 1 | Bit-time calibration complete |
| hdr_sent_i | input | 1 | Frame header transmitted strobe |
| tx_done_i | input | 1 | Frame transmission complete pulse |
| tx_pend_o | output | 1 | Transmit request pending |
| tx_data_o | output | WIDTH | Port snapshot for the data field |

## Verification
A pin change reaches tx_pend_o three edges after it is applied: two synchroniser stages, then the pending register. Poll, done and calibration effects show one edge after they are sampled. A header strobe updates tx_data_o at that edge, with data two edges old. The directed checks drive inputs at falling edges and wait the matching number of falling edges before sampling, one cycle short of the edge latency to prove nothing arrives early. A behavioural model built on a delay queue of pin values predicts both outputs. It is compared at every falling edge through a long random phase that includes collisions between triggers and done.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic {
    CFG_RISE = 1'b0,
    CFG_FALL = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/pec_sync.sv
module pec_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pec_edge_detect.sv
module pec_edge_detect #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] rise_mask_i,
  input  logic [WIDTH-1:0] fall_mask_i,
  output logic             hit_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rise_w, fall_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  assign rise_w = sync_i & ~prev_q & rise_mask_i;
  assign fall_w = ~sync_i & prev_q & fall_mask_i;
  assign hit_o  = |(rise_w | fall_w);
endmodule

// File: rtl/pec_req_ctrl.sv
module pec_req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_hit_i,
  input  logic poll_i,
  input  logic signon_i,
  input  logic calib_i,
  input  logic done_i,
  output logic signon_fire_o,
  output logic pend_o
);
  logic signon_wait_q;
  logic pend_q;
  logic trig_w;

  assign signon_fire_o = signon_wait_q & calib_i;
  assign trig_w        = edge_hit_i | poll_i | signon_fire_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) signon_wait_q <= 1'b0;
    else         signon_wait_q <= signon_i | (signon_wait_q & ~calib_i);
  end

  // trigger wins over done so a colliding event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= trig_w | (pend_q & ~done_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/port_event_capture.sv
module port_event_capture
  import pec_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_sel_i,
  input  logic [WIDTH-1:0] cfg_data_i,
  input  logic             poll_req_i,
  input  logic             signon_req_i,
  input  logic             calib_done_i,
  input  logic             hdr_sent_i,
  input  logic             tx_done_i,
  output logic             tx_pend_o,
  output logic [WIDTH-1:0] tx_data_o
);
  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] rise_mask_q, fall_mask_q;
  logic [WIDTH-1:0] tx_data_q;
  logic             edge_hit;
  logic             signon_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_mask_q <= '0;
      fall_mask_q <= '0;
    end else if (cfg_wr_i) begin
      unique case (cfg_sel_e'(cfg_sel_i))
        CFG_RISE: rise_mask_q <= cfg_data_i;
        CFG_FALL: fall_mask_q <= cfg_data_i;
      endcase
    end
  end

  pec_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pins_sync)
  );

  pec_edge_detect #(.WIDTH(WIDTH)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (pins_sync),
    .rise_mask_i (rise_mask_q),
    .fall_mask_i (fall_mask_q),
    .hit_o       (edge_hit)
  );

  pec_req_ctrl u_req (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .edge_hit_i    (edge_hit),
    .poll_i        (poll_req_i),
    .signon_i      (signon_req_i),
    .calib_i       (calib_done_i),
    .done_i        (tx_done_i),
    .signon_fire_o (signon_fire),
    .pend_o        (tx_pend_o)
  );

  // snapshot taken late, at header strobe, not at the edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      tx_data_q <= '0;
    else if (hdr_sent_i && tx_pend_o) tx_data_q <= pins_sync;
  end

  assign tx_data_o = tx_data_q;
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             poll_req_i,
  input logic             hdr_sent_i,
  input logic             tx_done_i,
  input logic             tx_pend_o,
  input logic [WIDTH-1:0] tx_data_o,
  input logic [WIDTH-1:0] pins_sync,
  input logic             edge_hit,
  input logic             signon_fire
);
  p_edge_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_hit |=> tx_pend_o);

  p_quiet_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_pend_o && !edge_hit && !poll_req_i && !signon_fire) |=> !tx_pend_o);

  p_data_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_sent_i && tx_pend_o) |=> (tx_data_o == $past(pins_sync)));

  p_poll_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_req_i |=> tx_pend_o);

  p_signon_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    signon_fire |=> tx_pend_o);

  p_pend_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pend_o && !tx_done_i) |=> tx_pend_o);

  p_done_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !edge_hit && !poll_req_i && !signon_fire) |=> !tx_pend_o);

  p_done_collide_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && (edge_hit || poll_req_i)) |=> tx_pend_o);

  p_data_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_sent_i && tx_pend_o) |=> $stable(tx_data_o));
endmodule

bind port_event_capture pec_checker #(.WIDTH(WIDTH)) u_pec_chk (.*);

// File: tb/port_event_capture_tb_top.sv
module port_event_capture_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] pins = '0;
  logic         cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [W-1:0] cfg_data = '0;
  logic         poll = 1'b0, signon = 1'b0, calib = 1'b0, hdr = 1'b0, done = 1'b0;
  logic         tx_pend;
  logic [W-1:0] tx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  port_event_capture #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins),
    .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .poll_req_i(poll), .signon_req_i(signon), .calib_done_i(calib),
    .hdr_sent_i(hdr), .tx_done_i(done),
    .tx_pend_o(tx_pend), .tx_data_o(tx_data)
  );

  // behavioural reference
  logic [W-1:0] m_pipe[$];
  logic [W-1:0] m_prev, m_rise, m_fall, m_data;
  bit           m_pend, m_wait;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pipe = {16'h0, 16'h0};
      m_prev = '0; m_rise = '0; m_fall = '0; m_data = '0;
      m_pend = 0; m_wait = 0;
    end else begin
      logic [W-1:0] cur;
      bit trig, fire;
      cur  = m_pipe[0];
      fire = m_wait && calib;
      trig = ((cur & ~m_prev & m_rise) != 0) || ((~cur & m_prev & m_fall) != 0)
             || poll || fire;
      if (hdr && m_pend) m_data = cur;
      m_pend = trig || (m_pend && !done);
      m_wait = signon || (m_wait && !calib);
      if (cfg_wr) begin
        if (cfg_sel) m_fall = cfg_data;
        else         m_rise = cfg_data;
      end
      m_prev = cur;
      m_pipe.push_back(pins);
      void'(m_pipe.pop_front());
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R9 model tx_pend", {15'b0, tx_pend}, {15'b0, m_pend});
      chk("R5 model tx_data", tx_data, m_data);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mask(bit sel, logic [W-1:0] val);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = val;
    cyc(1);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1; cyc(1); done = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1 reset pend", {15'b0, tx_pend}, '0);
    chk("R1 reset data", tx_data, '0);
    rst_ni = 1'b1;
    cyc(2);
    pins = 16'h0001; cyc(4);
    chk("R1 masks zero no trigger", {15'b0, tx_pend}, '0);
    pins = 16'h0000; cyc(4);
    chk("R4 unarmed pin ignored", {15'b0, tx_pend}, '0);

    wr_mask(1'b0, 16'h0001);                               // R13 rise mask write
    pins = 16'h0001; cyc(2);
    chk("R2 not before third edge", {15'b0, tx_pend}, '0);
    cyc(1);
    chk("R2 rise triggers", {15'b0, tx_pend}, 1);
    pins = 16'h0003; cyc(3);
    hdr = 1'b1; cyc(1); hdr = 1'b0;
    chk("R6 late change captured", tx_data, 16'h0003);
    chk("R9 header keeps pend", {15'b0, tx_pend}, 1);
    pulse_done();
    chk("R9 done clears", {15'b0, tx_pend}, '0);
    pins = 16'h0005; cyc(3);
    hdr = 1'b1; cyc(1); hdr = 1'b0;
    chk("R12 no load when idle", tx_data, 16'h0003);
    chk("R2 fall ignored with rise only", {15'b0, tx_pend}, '0);

    wr_mask(1'b1, 16'h0002);                               // R13 fall mask write
    pins = 16'h0007; cyc(4);
    chk("R3 rise ignored with fall only", {15'b0, tx_pend}, '0);
    pins = 16'h0005; cyc(3);
    chk("R3 fall triggers", {15'b0, tx_pend}, 1);
    pulse_done();
    wr_mask(1'b0, 16'h0003);
    pins = 16'h0007; cyc(3);
    chk("R3 both armed rise", {15'b0, tx_pend}, 1);
    pulse_done();
    pins = 16'h0005; cyc(3);
    chk("R3 both armed fall", {15'b0, tx_pend}, 1);
    pulse_done();
    chk("R9 cleared", {15'b0, tx_pend}, '0);

    pins = 16'h0007; cyc(3);
    pins = 16'h0005; cyc(3);
    pulse_done();
    chk("R10 merged edges one frame", {15'b0, tx_pend}, '0);
    cyc(2);
    chk("R10 stays idle", {15'b0, tx_pend}, '0);

    poll = 1'b1; cyc(1); poll = 1'b0;
    chk("R7 poll raises pend", {15'b0, tx_pend}, 1);
    pins = 16'h0007; cyc(2);
    pulse_done();
    chk("R11 edge with done keeps pend", {15'b0, tx_pend}, 1);
    pulse_done();
    chk("R11 then clears", {15'b0, tx_pend}, '0);

    signon = 1'b1; cyc(1); signon = 1'b0;
    cyc(3);
    chk("R8 waits for calibration", {15'b0, tx_pend}, '0);
    calib = 1'b1; cyc(1);
    chk("R8 sign-on after calibration", {15'b0, tx_pend}, 1);
    pulse_done();
    cyc(2);
    chk("R8 sign-on sent once", {15'b0, tx_pend}, '0);

    wr_mask(1'b0, '0);
    wr_mask(1'b1, '0);
    pins = 16'h0000; cyc(4);
    chk("R4 cleared masks ignore edge", {15'b0, tx_pend}, '0);
    poll = 1'b1; cyc(1); poll = 1'b0;
    chk("R7 poll with masks zero", {15'b0, tx_pend}, 1);
    pulse_done();

    for (int i = 0; i < 3000; i++) begin
      pins   = ($urandom_range(0, 3) == 0) ? W'($urandom) : pins;
      poll   = ($urandom_range(0, 15) == 0);
      hdr    = ($urandom_range(0, 3) == 0);
      done   = ($urandom_range(0, 4) == 0);
      signon = ($urandom_range(0, 63) == 0);
      calib  = ($urandom_range(0, 2) != 0);
      cfg_wr = ($urandom_range(0, 31) == 0);
      cfg_sel  = 1'($urandom);
      cfg_data = W'($urandom);
      cyc(1);
    end
    {poll, hdr, done, signon, cfg_wr} = '0;
    cyc(4);
    finish_run();
  end
endmodule